// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers eighteen interrupt source lines, records each rising request edge in a pending bit, and presents one interrupt request and a vector address to the processor. Most sources pass through two gates before they can win. The first is a global enable, which is the enable bit of the processor status word and arrives on its own input. The second is a per-source mask bit. Three sources are non-maskable, and both gates leave them untouched.

Arbitration is fixed: the lowest source number wins. The vector table is split into two ranges that do not touch, with two bytes per entry. Sources 0 to 10 map to 2000h + 2n. Sources 11 to 17 map to 2030h + 2(n-11).

Software sees four registers through a small write port and a registered read port:
- two pending registers, so software can trigger or cancel a request;
- two mask registers.

An acknowledge from the processor clears only the pending bit of the vector being served.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all pending and mask bits are 0, irq_req is 0, irq_vec is 2000h, irq_id is 0, and every register reads 0.
- R2: A pending bit is set by a 0-to-1 transition of its source line. A line held high does not set the bit again after it is cleared. irq_req follows two clock edges after the edge of the clock at which the line is first seen high.
- R3: When several sources are eligible, the one with the lowest number is served.
- R4: For source n, irq_vec equals 2000h+2n when n is 0 to 10, and 2030h+2(n-11) when n is 11 to 17. irq_id equals n.
- R5: A maskable source is eligible only when its pending bit, its mask bit and int_enable are all 1. The pending bit still latches while the source is blocked.
- R6: Sources 8, 9 and 15 are non-maskable. They are eligible whenever pending, whatever int_enable and the mask bits hold.
- R7: irq_ack while irq_req is 1 clears only the served source's pending bit, and the next vector is chosen at that same edge. If a new edge arrives on the served source in the acknowledge cycle, the bit stays set.
- R8: While irq_req is held and no acknowledge is given, irq_vec and irq_id do not change, even if a higher-priority source becomes pending.
- R9: Register select codes are 0 for pending low (sources 0-7 in bits 7:0), 1 for pending high (sources 8-17 in bits 9:0), 2 for mask low and 3 for mask high. rd_data shows the selected register one clock edge after rd_sel is applied. Bits above a register's width read as 0 and are ignored on write.
- R10: A write to a pending register replaces those pending bits. A 1 raises a request exactly as a source edge would, and a 0 cancels one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 18 | Source request lines, bit n for source n |
| int_enable | input | 1 | Global enable bit from the status word |
| irq_ack | input | 1 | Processor accepts the presented vector |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for writes |
| reg_wdata | input | 10 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 10 | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 16 | Vector address of the source being served |
| irq_id | output | 5 | Number of the source being served |

## Verification
A pending bit that is lost or set wrongly shows up two edges after the source edge, as a request that never comes or a request that should not exist. The register readback exposes it one edge after the read is selected. A wrong arbitration or masking decision appears on irq_vec and irq_id in the very cycle irq_req rises. A faulty acknowledge clear shows at the next edge, as the same vector being presented again or a surviving request disappearing. Broken holding logic is visible as a vector that moves while the request stays high.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int VEC_W = 16;

  typedef enum logic [1:0] {
    SEL_PEND_LO = 2'd0,
    SEL_PEND_HI = 2'd1,
    SEL_MASK_LO = 2'd2,
    SEL_MASK_HI = 2'd3
  } reg_sel_e;

  // Vector address of one source: two separate ranges, two bytes per entry.
  function automatic logic [VEC_W-1:0] vec_of(input int idx, input int split,
                                               input logic [VEC_W-1:0] base_a,
                                               input logic [VEC_W-1:0] base_b);
    if (idx < split) return base_a + VEC_W'(2 * idx);
    else             return base_b + VEC_W'(2 * (idx - split));
  endfunction

endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int N     = 18,
  parameter int LO_W  = 8,
  localparam int RW   = N - LO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_req,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [RW-1:0] wdata,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] src_edge
);

  logic [N-1:0] src_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_nxt;

  assign src_edge = src_req & ~src_q;

  // Order of effects: software write, then acknowledge clear, then edge set.
  always_comb begin
    pend_nxt = pend_q;
    if (we_lo) pend_nxt[LO_W-1:0] = wdata[LO_W-1:0];
    if (we_hi) pend_nxt[N-1:LO_W] = wdata[RW-1:0];
    pend_nxt = (pend_nxt & ~ack_clr) | src_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_req;
      pend_q <= pend_nxt;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irqv_maskreg.sv
module irqv_maskreg #(
  parameter int N     = 18,
  parameter int LO_W  = 8,
  localparam int RW   = N - LO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_lo,
  input  logic         we_hi,
  input  logic [RW-1:0] wdata,
  output logic [N-1:0] mask
);

  logic [LO_W-1:0] lo_q;
  logic [RW-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (we_lo) lo_q <= wdata[LO_W-1:0];
      if (we_hi) hi_q <= wdata;
    end
  end

  assign mask = {hi_q, lo_q};

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int               N       = 18,
  parameter int               SPLIT   = 11,
  parameter logic [VEC_W-1:0] BASE_A  = 16'h2000,
  parameter logic [VEC_W-1:0] BASE_B  = 16'h2030,
  parameter logic [N-1:0]     NMI_SET = 18'h08300,
  localparam int              IDW     = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     mask,
  input  logic             glb_en,
  input  logic             ack,
  output logic [N-1:0]     ack_clr,
  output logic             req,
  output logic [VEC_W-1:0] vec,
  output logic [IDW-1:0]   id
);

  logic [VEC_W-1:0] vec_tab [N];

  for (genvar g = 0; g < N; g++) begin : g_vec
    assign vec_tab[g] = vec_of(g, SPLIT, BASE_A, BASE_B);
  end

  logic [N-1:0]     elig;
  logic [N-1:0]     cand;
  logic             served;
  logic             hold;
  logic             found;
  logic [IDW-1:0]   win;
  logic             req_q;
  logic [VEC_W-1:0] vec_q;
  logic [IDW-1:0]   id_q;

  assign elig    = pend & (NMI_SET | (mask & {N{glb_en}}));
  assign served  = req_q & ack;
  assign ack_clr = served ? (N'(1) << id_q) : '0;
  assign cand    = elig & ~ack_clr;
  assign hold    = req_q & ~ack;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        win   = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      id_q  <= '0;
      vec_q <= BASE_A;
    end else if (hold) begin
      req_q <= elig[id_q];
    end else begin
      req_q <= found;
      id_q  <= win;
      vec_q <= vec_tab[win];
    end
  end

  assign req = req_q;
  assign vec = vec_q;
  assign id  = id_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int               N       = 18,
  parameter int               LO_W    = 8,
  parameter int               SPLIT   = 11,
  parameter logic [VEC_W-1:0] BASE_A  = 16'h2000,
  parameter logic [VEC_W-1:0] BASE_B  = 16'h2030,
  parameter logic [N-1:0]     NMI_SET = 18'h08300,
  localparam int              RW      = N - LO_W,
  localparam int              IDW     = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src_req,
  input  logic             int_enable,
  input  logic             irq_ack,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [RW-1:0]    reg_wdata,
  input  logic [1:0]       rd_sel,
  output logic [RW-1:0]    rd_data,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [IDW-1:0]   irq_id
);

  logic [N-1:0] pend_w;
  logic [N-1:0] mask_w;
  logic [N-1:0] edge_w;
  logic [N-1:0] clr_w;
  logic         pwe_lo, pwe_hi, mwe_lo, mwe_hi;
  logic [RW-1:0] rd_q;

  assign pwe_lo = reg_we && (reg_sel == SEL_PEND_LO);
  assign pwe_hi = reg_we && (reg_sel == SEL_PEND_HI);
  assign mwe_lo = reg_we && (reg_sel == SEL_MASK_LO);
  assign mwe_hi = reg_we && (reg_sel == SEL_MASK_HI);

  irqv_pending #(.N(N), .LO_W(LO_W)) u_pend (
    .clk(clk), .rst(rst), .src_req(src_req),
    .we_lo(pwe_lo), .we_hi(pwe_hi), .wdata(reg_wdata),
    .ack_clr(clr_w), .pend(pend_w), .src_edge(edge_w)
  );

  irqv_maskreg #(.N(N), .LO_W(LO_W)) u_mask (
    .clk(clk), .rst(rst),
    .we_lo(mwe_lo), .we_hi(mwe_hi), .wdata(reg_wdata),
    .mask(mask_w)
  );

  irqv_arbiter #(.N(N), .SPLIT(SPLIT), .BASE_A(BASE_A), .BASE_B(BASE_B),
                 .NMI_SET(NMI_SET)) u_arb (
    .clk(clk), .rst(rst), .pend(pend_w), .mask(mask_w), .glb_en(int_enable),
    .ack(irq_ack), .ack_clr(clr_w), .req(irq_req), .vec(irq_vec), .id(irq_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (reg_sel_e'(rd_sel))
        SEL_PEND_LO: rd_q <= RW'(pend_w[LO_W-1:0]);
        SEL_PEND_HI: rd_q <= pend_w[N-1:LO_W];
        SEL_MASK_LO: rd_q <= RW'(mask_w[LO_W-1:0]);
        SEL_MASK_HI: rd_q <= mask_w[N-1:LO_W];
        default:     rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int           N       = 18,
  parameter int           SPLIT   = 11,
  parameter logic [15:0]  BASE_A  = 16'h2000,
  parameter logic [15:0]  BASE_B  = 16'h2030,
  parameter logic [N-1:0] NMI_SET = 18'h08300,
  localparam int          IDW     = $clog2(N)
) (
  input logic           clk,
  input logic           rst,
  input logic           irq_req,
  input logic           irq_ack,
  input logic [15:0]    irq_vec,
  input logic [IDW-1:0] irq_id,
  input logic [N-1:0]   pend,
  input logic [N-1:0]   mask,
  input logic           glb_en,
  input logic [N-1:0]   src_edge,
  input logic           reg_we
);

  localparam logic [15:0] TOP_A = BASE_A + 16'(2 * (SPLIT - 1));
  localparam logic [15:0] TOP_B = BASE_B + 16'(2 * (N - 1 - SPLIT));

  logic [N-1:0] prev_ok;

  always_ff @(posedge clk) begin
    if (rst) prev_ok <= '0;
    else     prev_ok <= pend & (NMI_SET | (mask & {N{glb_en}}));
  end

  assert_vec_range_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (!irq_vec[0] &&
                 ((irq_vec >= BASE_A && irq_vec <= TOP_A) ||
                  (irq_vec >= BASE_B && irq_vec <= TOP_B))));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (!irq_req || ($stable(irq_vec) && $stable(irq_id))));

  // R5 and R6: a newly raised request must belong to an eligible source.
  assert_grant_legal_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> prev_ok[irq_id]);

  assert_fixed_prio_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> ((prev_ok & ((N'(1) << irq_id) - N'(1))) == '0));

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack && !reg_we) |=> (pend[$past(irq_id)] == $past(src_edge[irq_id])));

endmodule

bind irq_vector_ctrl irqv_chk #(
  .N(N), .SPLIT(SPLIT), .BASE_A(BASE_A), .BASE_B(BASE_B), .NMI_SET(NMI_SET)
) u_irqv_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
  .irq_vec(irq_vec), .irq_id(irq_id), .pend(pend_w), .mask(mask_w),
  .glb_en(int_enable), .src_edge(edge_w), .reg_we(reg_we)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] src_req = '0;
  logic        int_enable = 1'b0;
  logic        irq_ack = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [9:0]  reg_wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [9:0]  rd_data;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic [4:0]  irq_id;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst(rst), .src_req(src_req), .int_enable(int_enable),
    .irq_ack(irq_ack), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_id(irq_id)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int vexp(input int n);
    return (n <= 10) ? (32'h2000 + 2 * n) : (32'h2030 + 2 * (n - 11));
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [9:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [9:0] d);
    rd_sel = sel;
    tick();
    d = rd_data;
  endtask

  task automatic pulse(input int n);
    src_req[n] = 1'b1;
    tick();
    src_req[n] = 1'b0;
  endtask

  task automatic ack_now();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic expect_vec(input int n, input string tag);
    chk(irq_req === 1'b1, {tag, " req"}, irq_req, 1);
    chk(irq_vec === vexp(n), {tag, " vec"}, irq_vec, vexp(n));
    chk(irq_id === n, {tag, " id"}, irq_id, n);
  endtask

  task automatic t_reset();
    logic [9:0] d;
    chk(irq_req === 1'b0, "R1 req", irq_req, 0);
    chk(irq_vec === 16'h2000, "R1 vec", irq_vec, 16'h2000);
    chk(irq_id === 5'd0, "R1 id", irq_id, 0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk(d === 10'h0, "R1 reg", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [9:0] d;
    wr(2'd3, 10'h3FF);
    wr(2'd2, 10'h3FF);
    rd(2'd3, d); chk(d === 10'h3FF, "R9 mask hi", d, 10'h3FF);
    rd(2'd2, d); chk(d === 10'h0FF, "R9 mask lo width", d, 10'h0FF);
  endtask

  task automatic t_map();
    for (int n = 0; n < 18; n++) begin
      pulse(n);
      chk(irq_req === 1'b0, "R2 latency", irq_req, 0);
      tick();
      expect_vec(n, "R4 map");
      ack_now();
      chk(irq_req === 1'b0, "R7 ack drop", irq_req, 0);
    end
  endtask

  task automatic t_prio();
    src_req[12] = 1'b1; src_req[3] = 1'b1;
    tick();
    src_req = '0;
    tick();
    expect_vec(3, "R3 first");
    ack_now();
    expect_vec(12, "R3 second");
    ack_now();
    chk(irq_req === 1'b0, "R3 empty", irq_req, 0);
  endtask

  task automatic t_hold();
    pulse(10);
    tick();
    expect_vec(10, "R8 start");
    pulse(1);
    tick(); tick();
    expect_vec(10, "R8 held");
    ack_now();
    expect_vec(1, "R8 next");
    ack_now();
  endtask

  task automatic t_mask();
    logic [9:0] d;
    wr(2'd2, 10'h0EF);
    pulse(4);
    tick(); tick();
    chk(irq_req === 1'b0, "R5 masked", irq_req, 0);
    rd(2'd0, d); chk(d === 10'h010, "R5 latched", d, 10'h010);
    wr(2'd2, 10'h0FF);
    tick();
    expect_vec(4, "R5 unmasked");
    ack_now();
    int_enable = 1'b0;
    pulse(5);
    tick(); tick();
    chk(irq_req === 1'b0, "R5 global off", irq_req, 0);
    int_enable = 1'b1;
    tick();
    expect_vec(5, "R5 global on");
    ack_now();
  endtask

  task automatic t_nmi();
    logic [9:0] d;
    int_enable = 1'b0;
    wr(2'd2, 10'h0); wr(2'd3, 10'h0);
    pulse(3);
    tick(); tick();
    chk(irq_req === 1'b0, "R6 maskable blocked", irq_req, 0);
    pulse(9);
    tick();
    expect_vec(9, "R6 nmi9");
    ack_now();
    pulse(15);
    tick();
    expect_vec(15, "R6 nmi15");
    ack_now();
    wr(2'd0, 10'h0);
    rd(2'd0, d); chk(d === 10'h0, "R10 clear", d, 0);
    wr(2'd2, 10'h0FF); wr(2'd3, 10'h3FF);
    int_enable = 1'b1;
    tick();
    chk(irq_req === 1'b0, "R10 cleared no req", irq_req, 0);
  endtask

  task automatic t_ack_edge();
    logic [9:0] d;
    src_req[2] = 1'b1; src_req[6] = 1'b1;
    tick();
    src_req = '0;
    tick();
    expect_vec(2, "R7 first");
    src_req[2] = 1'b1; irq_ack = 1'b1;
    tick();
    src_req[2] = 1'b0; irq_ack = 1'b0;
    expect_vec(6, "R7 after ack");
    rd(2'd0, d); chk(d === 10'h044, "R7 edge wins", d, 10'h044);
    ack_now();
    expect_vec(2, "R7 re-served");
    ack_now();
    rd(2'd0, d); chk(d === 10'h0, "R7 all clear", d, 0);
  endtask

  task automatic t_level();
    logic [9:0] d;
    src_req[7] = 1'b1;
    tick(); tick();
    expect_vec(7, "R2 level");
    ack_now();
    tick(); tick(); tick();
    chk(irq_req === 1'b0, "R2 no retrigger", irq_req, 0);
    rd(2'd0, d); chk(d === 10'h0, "R2 pend clear", d, 0);
    src_req[7] = 1'b0;
  endtask

  task automatic t_swwrite();
    logic [9:0] d;
    wr(2'd1, 10'h020);
    tick();
    expect_vec(13, "R10 sw set");
    ack_now();
    wr(2'd2, 10'h07F);
    wr(2'd0, 10'h080);
    rd(2'd0, d); chk(d === 10'h080, "R10 sw pend", d, 10'h080);
    chk(irq_req === 1'b0, "R10 masked sw", irq_req, 0);
    wr(2'd0, 10'h0);
    rd(2'd0, d); chk(d === 10'h0, "R10 sw cancel", d, 0);
    wr(2'd2, 10'h0FF);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    int_enable = 1'b1;
    t_regs();
    t_map();
    t_prio();
    t_hold();
    t_mask();
    t_nmi();
    t_ack_edge();
    t_level();
    t_swwrite();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule